// File: doc/BRIEF.md
# Ethernet PHY Reset Sequencer

This block turns every reset source of a 10/100 Ethernet PHY into three internal reset domains and a busy indication. The sources are an on-chip power-on reset, an active-low board reset pin, and three self-clearing control bits in the management register file. The domains are the standard registers, the extended registers and the datapath circuits. A fourth output tells the strap logic to sample the configuration pins again.

The sources differ in reach. The control bit at address 0x00 clears only the standard registers. The global bit at address 0x1F clears all registers and the datapath, but the straps keep their values. The restart bit at address 0x1F resets only the datapath and leaves the registers intact. A power-on or pin reset does all of these and also reloads the straps. Every sequence holds its outputs for a settling time of about 200 µs. The settling time and the minimum pin pulse width are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `phy_rst_seq`

## Requirements
- R1: While `por_n` is low, `rst_std`, `rst_ext`, `rst_core`, `strap_load` and `busy` are all 1 and the three pending bits are 0. After `por_n` rises, they stay 1 for exactly SETTLE clock edges and then fall together.
- R2: A low pulse on `rst_pin_n` that spans fewer than PIN_MIN clock cycles leaves every output unchanged.
- R3: A low level on `rst_pin_n` that is held well beyond PIN_MIN cycles drives all four reset outputs and `busy` to 1. They stay high while the pin is low. After the pin rises, they stay high for SETTLE+1 more falling clock edges (two synchroniser stages included) and then fall.
- R4: A write to address 0x00 with data bit 15 set drives `rst_std` to 1 from the next cycle, with `rst_ext`, `rst_core` and `strap_load` held at 0. `busy` then lasts exactly SETTLE cycles.
- R5: A write to address 0x1F with data bit 15 set drives `rst_std`, `rst_ext` and `rst_core` to 1 and keeps `strap_load` at 0 for SETTLE cycles.
- R6: A write to address 0x1F with data bit 14 set drives only `rst_core` to 1 for SETTLE cycles.
- R7: Writes to any other address, and writes to 0x00 or 0x1F with the relevant bits clear, change no output.
- R8: Each pending bit (`pend_std` for 0x00 bit 15, `pend_all` for 0x1F bit 15, `pend_restart` for 0x1F bit 14) reads 1 from the cycle after its write. It returns to 0 in the same cycle that `busy` falls.
- R9: A request that arrives while a sequence runs reloads the full SETTLE count. The request's scope is added to the active one, and no reset output falls before `busy` does.
- R10: A reset output is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency given by CLK_HZ |
| por_n | input | 1 | Power-on reset from the on-chip detector, active low, asynchronous |
| rst_pin_n | input | 1 | Board reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe from the management interface |
| wr_addr | input | AW | Register address of the write |
| wr_data | input | DW | Register data of the write |
| rst_std | output | 1 | Clears the standard registers |
| rst_ext | output | 1 | Clears the extended registers |
| rst_core | output | 1 | Resets the datapath circuits |
| strap_load | output | 1 | Samples the strap configuration again |
| busy | output | 1 | A reset sequence is in progress |
| pend_std | output | 1 | Read value of the standard-register reset bit |
| pend_all | output | 1 | Read value of the global reset bit |
| pend_restart | output | 1 | Read value of the restart bit |

## Verification
Timer expiry and a new request can fall on the same clock edge: the last cycle of one sequence can also be the first cycle of another. The bench provokes this with a standard-register reset, then issues a restart write timed so that it is sampled on the edge where the count would reach its end. The result is judged correct only if `busy` does not drop for even one cycle, `rst_std` stays high next to the newly added `rst_core`, and the combined sequence then runs a full fresh SETTLE period.

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned PIN_MIN_US = 1,
  parameter int unsigned SETTLE_US  = 200,
  parameter int unsigned AW         = 5,
  parameter int unsigned DW         = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_pin_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rst_std,
  output logic          rst_ext,
  output logic          rst_core,
  output logic          strap_load,
  output logic          busy,
  output logic          pend_std,
  output logic          pend_all,
  output logic          pend_restart
);
  localparam int unsigned CYC_US     = (CLK_HZ / 1_000_000) > 0 ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned PIN_CYC    = PIN_MIN_US * CYC_US;
  localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_US;
  localparam int unsigned TW         = $clog2(SETTLE_CYC + 1);
  localparam int unsigned PW         = $clog2(PIN_CYC + 1);
  localparam logic [TW-1:0] T_LOAD   = TW'(SETTLE_CYC - 1);
  localparam logic [PW-1:0] P_MAX    = PW'(PIN_CYC);
  localparam logic [AW-1:0] A_STD    = AW'(0);
  localparam logic [AW-1:0] A_CTL    = AW'(31);
  localparam int unsigned B_STD      = 15;
  localparam int unsigned B_ALL      = 15;
  localparam int unsigned B_RESTART  = 14;

  logic [1:0]    pin_sync;
  logic [PW-1:0] low_cnt;
  logic [TW-1:0] timer;
  logic [3:0]    scope;
  logic [2:0]    pend;
  logic          active;

  wire pin_low  = ~pin_sync[1];
  wire pin_hold = pin_low && (low_cnt == P_MAX);
  wire w_std    = wr_en && (wr_addr == A_STD) && wr_data[B_STD];
  wire w_all    = wr_en && (wr_addr == A_CTL) && wr_data[B_ALL];
  wire w_rst    = wr_en && (wr_addr == A_CTL) && wr_data[B_RESTART];

  wire [3:0] req = {pin_hold,
                    pin_hold | w_all | w_rst,
                    pin_hold | w_all,
                    pin_hold | w_all | w_std};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_sync <= 2'b11;
      low_cnt  <= '0;
    end else begin
      pin_sync <= {pin_sync[0], rst_pin_n};
      if (!pin_low)
        low_cnt <= '0;
      else if (low_cnt != P_MAX)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      scope  <= 4'hF;
      timer  <= T_LOAD;
      active <= 1'b1;
      pend   <= '0;
    end else if (|req) begin
      scope  <= scope | req;
      timer  <= T_LOAD;
      active <= 1'b1;
      pend   <= pend | {w_rst, w_all, w_std};
    end else if (active) begin
      if (timer == '0) begin
        active <= 1'b0;
        scope  <= '0;
        pend   <= '0;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  assign {strap_load, rst_core, rst_ext, rst_std} = scope;
  assign busy = active;
  assign {pend_restart, pend_all, pend_std} = pend;
endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_pin_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rst_std,
  input logic          rst_ext,
  input logic          rst_core,
  input logic          strap_load,
  input logic          busy,
  input logic          pend_std,
  input logic          pend_all,
  input logic          pend_restart
);
  wire c_std = wr_en && (wr_addr == AW'(0))  && wr_data[15];
  wire c_all = wr_en && (wr_addr == AW'(31)) && wr_data[15];
  wire c_rst = wr_en && (wr_addr == AW'(31)) && wr_data[14] && !wr_data[15];
  wire quiet = !busy && rst_pin_n;

  a_r4_std_only: assert property (@(posedge clk) disable iff (!por_n)
    c_std && !c_all && !c_rst && quiet |=> rst_std && !rst_ext && !rst_core && !strap_load);

  a_r5_global: assert property (@(posedge clk) disable iff (!por_n)
    c_all && quiet |=> rst_std && rst_ext && rst_core && !strap_load);

  a_r6_restart: assert property (@(posedge clk) disable iff (!por_n)
    c_rst && !c_std && quiet |=> rst_core && !rst_std && !rst_ext && !strap_load);

  a_r8_pend_set: assert property (@(posedge clk) disable iff (!por_n)
    c_std |=> pend_std);

  a_r8_pend_clear: assert property (@(posedge clk) disable iff (!por_n)
    $fell(busy) |-> !pend_std && !pend_all && !pend_restart);

  a_r9_std_held: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_std) |-> !busy);

  a_r9_core_held: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_core) |-> !busy);

  a_r10_only_busy: assert property (@(posedge clk) disable iff (!por_n)
    (rst_std || rst_ext || rst_core || strap_load) |-> busy);
endmodule

bind phy_rst_seq phy_rst_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/phy_rst_seq_tb.sv
module phy_rst_seq_tb;
  localparam int unsigned CLK_HZ = 10_000_000;
  localparam int SETTLE = 2000;
  localparam int PINMIN = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic rst_std, rst_ext, rst_core, strap_load, busy;
  logic pend_std, pend_all, pend_restart;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phy_rst_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_std(rst_std), .rst_ext(rst_ext), .rst_core(rst_core),
    .strap_load(strap_load), .busy(busy),
    .pend_std(pend_std), .pend_all(pend_all), .pend_restart(pend_restart)
  );

  wire [3:0] outs = {strap_load, rst_core, rst_ext, rst_std};
  wire [2:0] pend = {pend_restart, pend_all, pend_std};

  task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic write(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run_out(input string r, input int lead);
    repeat (lead) @(negedge clk);
    check(r, {7'd0, busy}, 8'd1);
    @(negedge clk);
    check(r, {3'd0, outs, busy}, 8'd0);
    check("R8", {5'd0, pend}, 8'd0);
  endtask

  task automatic t_por();
    repeat (3) @(negedge clk);
    check("R1", {3'd0, outs, busy}, 8'h1F);
    check("R1", {5'd0, pend}, 8'd0);
    por_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    check("R1", {3'd0, outs, busy}, 8'h1F);
    @(negedge clk);
    check("R1", {3'd0, outs, busy}, 8'd0);
  endtask

  task automatic t_glitch();
    int seen = 0;
    rst_pin_n = 1'b0;
    repeat (PINMIN / 2) @(negedge clk);
    rst_pin_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy || outs != 0) seen++;
    end
    check("R2", 8'(seen), 8'd0);
  endtask

  task automatic t_pin();
    rst_pin_n = 1'b0;
    repeat (3 * PINMIN) @(negedge clk);
    check("R3", {3'd0, outs, busy}, 8'h1F);
    rst_pin_n = 1'b1;
    run_out("R3", SETTLE + 1);
  endtask

  task automatic t_std();
    write(5'd0, 16'h8000);
    check("R4", {3'd0, outs, busy}, 8'h03);
    check("R8", {5'd0, pend}, 8'h1);
    run_out("R4", SETTLE - 1);
  endtask

  task automatic t_all();
    write(5'd31, 16'h8000);
    check("R5", {3'd0, outs, busy}, 8'h0F);
    check("R8", {5'd0, pend}, 8'h2);
    run_out("R5", SETTLE - 1);
  endtask

  task automatic t_restart();
    write(5'd31, 16'h4000);
    check("R6", {3'd0, outs, busy}, 8'h09);
    check("R8", {5'd0, pend}, 8'h4);
    run_out("R6", SETTLE - 1);
  endtask

  task automatic t_ignore();
    write(5'd0, 16'h7FFF);
    check("R7", {pend, outs, busy}, 8'd0);
    write(5'd31, 16'h3FFF);
    check("R7", {pend, outs, busy}, 8'd0);
    write(5'd5, 16'hC000);
    check("R7", {pend, outs, busy}, 8'd0);
  endtask

  task automatic t_merge();
    write(5'd0, 16'h8000);
    repeat (100) @(negedge clk);
    write(5'd31, 16'h4000);
    check("R9", {3'd0, outs, busy}, 8'h0B);
    check("R8", {5'd0, pend}, 8'h5);
    run_out("R9", SETTLE - 1);
  endtask

  task automatic t_collide();
    write(5'd0, 16'h8000);
    repeat (SETTLE - 1) @(negedge clk);
    write(5'd31, 16'h4000);
    check("R9", {3'd0, outs, busy}, 8'h0B);
    run_out("R9", SETTLE - 1);
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_por();
    t_glitch();
    t_pin();
    t_std();
    t_all();
    t_restart();
    t_ignore();
    t_merge();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule